// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits on a small processor's I/O bus. Software reaches it through three bus addresses. One holds the output data latch and one holds the direction register; both can be read and written. The third is a read-only address that returns the levels actually present on the pins, after a two-stage synchroniser. Software can also set or clear one bit of the latch or the direction register without a read-modify-write. To do this it gives a bit index, a target select and a set/clear flag.

For each pin the block produces three signals for an external pad model: the value to drive, an output enable and a pull-up enable. On a pin configured as an input, the latch bit serves as the pull-up enable. An external-memory enable hands the pins to a memory controller, which uses them as a multiplexed low address/data bus. While that enable is high, the controller's own drive value and enable replace the direction register and the latch. The stored registers stay writable during that time, and they take effect again when the enable drops.

Top module: `gpio_port`

## Requirements
- R1: After reset, the latch and direction registers read 0x00, and pad_oe and pad_pu are 0x00. Every pin starts as an input with its pull-up off.
- R2: A bus write to address 0x1B loads the data latch and a write to 0x1A loads the direction register. A read of either address returns the stored byte in the cycle after the write edge, because bus_rdata is combinational from bus_addr.
- R3: While xmem_en is low, pad_oe bit n equals direction bit n, with 1 meaning output. pad_out bit n equals latch bit n.
- R4: While xmem_en is low, pad_pu bit n is 1 exactly when direction bit n is 0 and latch bit n is 1.
- R5: A read of address 0x19 returns pad_in as it was sampled two clock edges earlier. After one edge, the read still shows the previous value.
- R6: A write to 0x19, or to any address other than 0x1A and 0x1B, changes no state. A read of an address other than 0x19, 0x1A and 0x1B returns 0x00.
- R7: A bit operation with bop_valid=1 acts on the latch when bop_tgt=0 and on the direction register when bop_tgt=1. It forces bit bop_idx to bop_set at the next edge and leaves every other bit of both registers unchanged.
- R8: If a byte write and a bit operation hit the same register in one cycle, the register takes the written byte with the bit operation applied on top of it.
- R9: While xmem_en is high, pad_oe equals alt_oe and pad_out equals alt_out. pad_pu is the inverse of alt_oe, so every pin not driven by the memory bus has its pull-up on.
- R10: While xmem_en is high, the latch and direction registers still accept writes and read back normally. When xmem_en goes low, the pad signals follow the stored values again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | I/O bus address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| bop_valid | input | 1 | Bit operation request |
| bop_tgt | input | 1 | Bit operation target: 0 latch, 1 direction |
| bop_idx | input | 3 | Bit operation index |
| bop_set | input | 1 | Value written by the bit operation |
| xmem_en | input | 1 | Memory bus takes over the pins |
| alt_oe | input | 8 | Memory bus output enables |
| alt_out | input | 8 | Memory bus drive values |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
Register writes and bit operations appear on bus_rdata and on the pad signals after the next rising edge. The pad override and the read-data mux are combinational, so they add no further cycle. A pin change takes two edges to reach the 0x19 read path. The bench therefore checks the old value after the first edge and the new one after the second.

Every stimulus is applied on a falling edge, and the bench queues the results it expects at that same falling edge. A monitor compares the queued results 2 ns after the following rising edge. This keeps each comparison inside the cycle where the result is due and ahead of the next change to the inputs.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    localparam int PORT_W = 8;
    localparam int IDX_W  = $clog2(PORT_W);
    localparam int ADDR_W = 6;

    typedef logic [PORT_W-1:0] port_t;

    // Which storage register a single-bit operation addresses
    typedef enum logic {
        TGT_LATCH = 1'b0,
        TGT_DIR   = 1'b1
    } bit_tgt_e;

    typedef struct packed {
        logic             valid;
        bit_tgt_e         tgt;
        logic [IDX_W-1:0] idx;
        logic             set;
    } bitop_t;

    typedef struct packed {
        port_t out;
        port_t oe;
        port_t pu;
    } pad_ctl_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_LATCH,
        RD_DIR,
        RD_PIN
    } rd_src_e;

    // Force one bit of a byte when hit is set
    function automatic port_t bit_update(port_t base, logic hit,
                                         logic [IDX_W-1:0] idx, logic val);
        port_t r;
        r = base;
        if (hit) r[idx] = val;
        return r;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_latch,
    input  logic   wr_dir,
    input  port_t  wdata,
    input  bitop_t bop,
    output port_t  latch_q,
    output port_t  dir_q
);

    localparam int NREG = 2;

    port_t    cur   [NREG];
    port_t    nxt   [NREG];
    logic     wr_en [NREG];
    bit_tgt_e tgt_of[NREG];

    assign wr_en[0]  = wr_latch;
    assign wr_en[1]  = wr_dir;
    assign tgt_of[0] = TGT_LATCH;
    assign tgt_of[1] = TGT_DIR;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            port_t staged;
            always_comb begin
                staged = wr_en[g] ? wdata : cur[g];
                nxt[g] = bit_update(staged, bop.valid && (bop.tgt == tgt_of[g]),
                                    bop.idx, bop.set);
            end
            always_ff @(posedge clk) begin
                if (rst) cur[g] <= '0;
                else     cur[g] <= nxt[g];
            end
        end
    endgenerate

    assign latch_q = cur[0];
    assign dir_q   = cur[1];

endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic  clk,
    input  logic  rst,
    input  port_t d,
    output port_t q
);

    port_t stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_padmux.sv
`timescale 1ns/1ps
module gpio_padmux
    import gpio_pkg::*;
(
    input  port_t    latch_q,
    input  port_t    dir_q,
    input  logic     alt_en,
    input  port_t    alt_oe,
    input  port_t    alt_out,
    output pad_ctl_t ctl
);

    always_comb begin
        if (alt_en) begin
            ctl.out = alt_out;
            ctl.oe  = alt_oe;
            ctl.pu  = ~alt_oe;
        end else begin
            ctl.out = latch_q;
            ctl.oe  = dir_q;
            ctl.pu  = ~dir_q & latch_q;
        end
    end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_LATCH  = 6'h1B,
    parameter logic [ADDR_W-1:0] ADDR_DIR    = 6'h1A,
    parameter logic [ADDR_W-1:0] ADDR_PIN    = 6'h19,
    parameter int                SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              bop_valid,
    input  logic              bop_tgt,
    input  logic [IDX_W-1:0]  bop_idx,
    input  logic              bop_set,
    input  logic              xmem_en,
    input  logic [PORT_W-1:0] alt_oe,
    input  logic [PORT_W-1:0] alt_out,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu
);

    port_t    latch_q;
    port_t    dir_q;
    port_t    pin_q;
    bitop_t   bop;
    pad_ctl_t ctl;
    rd_src_e  rd_src;
    logic     wr_latch;
    logic     wr_dir;

    // Address decode
    always_comb begin
        if      (bus_addr == ADDR_LATCH) rd_src = RD_LATCH;
        else if (bus_addr == ADDR_DIR)   rd_src = RD_DIR;
        else if (bus_addr == ADDR_PIN)   rd_src = RD_PIN;
        else                             rd_src = RD_NONE;
    end

    assign wr_latch = bus_wr && (rd_src == RD_LATCH);
    assign wr_dir   = bus_wr && (rd_src == RD_DIR);

    assign bop.valid = bop_valid;
    assign bop.tgt   = bit_tgt_e'(bop_tgt);
    assign bop.idx   = bop_idx;
    assign bop.set   = bop_set;

    gpio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_latch (wr_latch),
        .wr_dir   (wr_dir),
        .wdata    (bus_wdata),
        .bop      (bop),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_q)
    );

    gpio_padmux u_mux (
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .alt_en  (xmem_en),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .ctl     (ctl)
    );

    always_comb begin
        unique case (rd_src)
            RD_LATCH: bus_rdata = latch_q;
            RD_DIR:   bus_rdata = dir_q;
            RD_PIN:   bus_rdata = pin_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = ctl.out;
    assign pad_oe  = ctl.oe;
    assign pad_pu  = ctl.pu;

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_LATCH  = 6'h1B,
    parameter logic [ADDR_W-1:0] ADDR_DIR    = 6'h1A,
    parameter logic [ADDR_W-1:0] ADDR_PIN    = 6'h19,
    parameter int                SYNC_STAGES = 2
)(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic              bop_valid,
    input logic              bop_tgt,
    input logic [IDX_W-1:0]  bop_idx,
    input logic              bop_set,
    input logic              xmem_en,
    input logic [PORT_W-1:0] alt_oe,
    input logic [PORT_W-1:0] alt_out,
    input logic [PORT_W-1:0] pad_in,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_pu,
    input logic [PORT_W-1:0] latch_q,
    input logic [PORT_W-1:0] dir_q,
    input logic [PORT_W-1:0] pin_q
);

    logic       rst_seen_q;
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1: registers cleared by a reset edge
    always @(negedge clk) begin
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (latch_q == '0 && dir_q == '0);
        end
    end

    p_latch_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_LATCH && !bop_valid) |=> (latch_q == $past(bus_wdata)));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_DIR && !bop_valid) |=> (dir_q == $past(bus_wdata)));

    p_no_pullup_on_output_r4: assert property (@(posedge clk) disable iff (rst)
        !xmem_en |-> ((pad_pu & pad_oe) == '0));

    generate
        if (SYNC_STAGES == 2) begin : g_lat
            p_pin_latency_r5: assert property (@(posedge clk) disable iff (rst)
                (age_q >= 2'd2) |-> (pin_q == $past(pad_in, 2)));
        end
    endgenerate

    p_pin_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_PIN && !bop_valid)
        |=> (latch_q == $past(latch_q) && dir_q == $past(dir_q)));

    p_bitop_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (bop_valid && !bus_wr && bop_tgt == 1'b0)
        |=> (latch_q[$past(bop_idx)] == $past(bop_set)
             && $countones(latch_q ^ $past(latch_q)) <= 1
             && $stable(dir_q)));

    p_alt_override_r9: assert property (@(posedge clk) disable iff (rst)
        xmem_en |-> (pad_oe == alt_oe && pad_out == alt_out && pad_pu == ~alt_oe));

endmodule

bind gpio_port gpio_port_chk #(
    .ADDR_LATCH  (ADDR_LATCH),
    .ADDR_DIR    (ADDR_DIR),
    .ADDR_PIN    (ADDR_PIN),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bop_valid (bop_valid),
    .bop_tgt   (bop_tgt),
    .bop_idx   (bop_idx),
    .bop_set   (bop_set),
    .xmem_en   (xmem_en),
    .alt_oe    (alt_oe),
    .alt_out   (alt_out),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .pin_q     (pin_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;

    localparam logic [5:0] A_LATCH = 6'h1B;
    localparam logic [5:0] A_DIR   = 6'h1A;
    localparam logic [5:0] A_PIN   = 6'h19;

    localparam int SEL_RD  = 0;
    localparam int SEL_OE  = 1;
    localparam int SEL_OUT = 2;
    localparam int SEL_PU  = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       bop_valid;
    logic       bop_tgt;
    logic [2:0] bop_idx;
    logic       bop_set;
    logic       xmem_en;
    logic [7:0] alt_oe;
    logic [7:0] alt_out;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pad_pu;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];

    always #2.5 clk = ~clk;

    gpio_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bop_valid (bop_valid),
        .bop_tgt   (bop_tgt),
        .bop_idx   (bop_idx),
        .bop_set   (bop_set),
        .xmem_en   (xmem_en),
        .alt_oe    (alt_oe),
        .alt_out   (alt_out),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    // Expected result, due after the next rising edge
    task automatic expect_item(int sel, logic [7:0] exp, string req);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    SEL_RD:  act = bus_rdata;
                    SEL_OE:  act = pad_oe;
                    SEL_OUT: act = pad_out;
                    default: act = pad_pu;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver
    initial begin
        rst = 1'b1; bus_addr = A_LATCH; bus_wr = 1'b0; bus_wdata = '0;
        bop_valid = 1'b0; bop_tgt = 1'b0; bop_idx = '0; bop_set = 1'b0;
        xmem_en = 1'b0; alt_oe = '0; alt_out = '0; pad_in = '0;
        repeat (3) step();

        // R1: reset state
        rst = 1'b0;
        bus_addr = A_LATCH;
        expect_item(SEL_RD, 8'h00, "R1");
        expect_item(SEL_OE, 8'h00, "R1");
        expect_item(SEL_PU, 8'h00, "R1");
        step();
        bus_addr = A_DIR;
        expect_item(SEL_RD, 8'h00, "R1");
        step();

        // R2: byte writes and readback
        bus_wr = 1'b1; bus_addr = A_LATCH; bus_wdata = 8'hA5;
        expect_item(SEL_RD, 8'hA5, "R2");
        step();
        bus_addr = A_DIR; bus_wdata = 8'h3C;
        expect_item(SEL_RD, 8'h3C, "R2");
        step();

        // R3 / R4: normal pad control
        bus_wr = 1'b0;
        expect_item(SEL_OE,  8'h3C, "R3");
        expect_item(SEL_OUT, 8'hA5, "R3");
        expect_item(SEL_PU,  8'h81, "R4");
        step();

        // R5: two-edge pin latency
        pad_in = 8'h5A; bus_addr = A_PIN;
        expect_item(SEL_RD, 8'h00, "R5");
        step();
        expect_item(SEL_RD, 8'h5A, "R5");
        step();
        pad_in = 8'hC3;
        expect_item(SEL_RD, 8'h5A, "R5");
        step();
        expect_item(SEL_RD, 8'hC3, "R5");
        step();

        // R6: writes to pin and unused addresses ignored
        bus_wr = 1'b1; bus_addr = A_PIN; bus_wdata = 8'hFF;
        step();
        bus_addr = 6'h05;
        expect_item(SEL_RD, 8'h00, "R6");
        step();
        bus_wr = 1'b0; bus_addr = A_LATCH;
        expect_item(SEL_RD, 8'hA5, "R6");
        expect_item(SEL_OE, 8'h3C, "R6");
        step();
        bus_addr = A_DIR;
        expect_item(SEL_RD, 8'h3C, "R6");
        step();

        // R7: single-bit set and clear
        bop_valid = 1'b1; bop_tgt = 1'b0; bop_idx = 3'd6; bop_set = 1'b1;
        bus_addr = A_LATCH;
        expect_item(SEL_RD, 8'hE5, "R7");
        step();
        bop_tgt = 1'b1; bop_idx = 3'd2; bop_set = 1'b0;
        bus_addr = A_DIR;
        expect_item(SEL_RD, 8'h38, "R7");
        step();
        bop_idx = 3'd7; bop_set = 1'b1;
        expect_item(SEL_RD, 8'hB8, "R7");
        step();
        bop_valid = 1'b0; bus_addr = A_LATCH;
        expect_item(SEL_RD, 8'hE5, "R7");
        step();

        // R8: byte write and bit operation on the same register
        bus_wr = 1'b1; bus_addr = A_LATCH; bus_wdata = 8'h0F;
        bop_valid = 1'b1; bop_tgt = 1'b0; bop_idx = 3'd7; bop_set = 1'b1;
        expect_item(SEL_RD, 8'h8F, "R8");
        step();
        bus_wr = 1'b0; bop_valid = 1'b0;

        // R9: memory bus override
        xmem_en = 1'b1; alt_oe = 8'hF0; alt_out = 8'h99;
        expect_item(SEL_OE,  8'hF0, "R9");
        expect_item(SEL_OUT, 8'h99, "R9");
        expect_item(SEL_PU,  8'h0F, "R9");
        step();

        // R10: writes during override, effect after release
        bus_wr = 1'b1; bus_addr = A_LATCH; bus_wdata = 8'h33;
        expect_item(SEL_RD, 8'h33, "R10");
        expect_item(SEL_OE, 8'hF0, "R10");
        step();
        bus_addr = A_DIR; bus_wdata = 8'h0F;
        expect_item(SEL_RD,  8'h0F, "R10");
        expect_item(SEL_OUT, 8'h99, "R10");
        step();
        bus_wr = 1'b0; xmem_en = 1'b0;
        expect_item(SEL_OE,  8'h0F, "R10");
        expect_item(SEL_OUT, 8'h33, "R10");
        expect_item(SEL_PU,  8'h30, "R10");
        step();
        step();

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule